// File: doc/BRIEF.md
# Dirty Rectangle Queue with Clipping

This block gathers screen-update rectangles produced by a drawing engine and hands them, later and in the order they arrived, to a display refresh engine. Each entry carries a position (x, y) and a size (width, height). Entries accumulate silently until a flush request arrives. From then on the block presents one entry per cycle on a valid/ready stream, until the read position catches up with the write position.

Every rectangle is clipped against the screen width and height that are present at the moment it leaves the queue, not at the moment it was stored. A rectangle that extends past the right edge is cut off at that edge, and the bottom edge is handled the same way. When a start coordinate lies beyond the edge, it is pulled back to the edge. An entry whose width or height is zero after clipping is skipped without being presented.

A full-screen invalidate strobe arms a pending flag. The next flush then discards all stored entries at once instead of draining them, because a full redraw makes them redundant. The storage is a power-of-two ring. A push into a full ring overwrites the oldest entry and sets a sticky overflow flag.

Top module: `dirty_rect_queue`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1), `out_valid_o`=0 and `overflow_o`=0.
- R2: After a flush with no invalidate pending, stored rectangles come out in push order, and `empty_o` is 1 once the drain completes.
- R3: While `out_valid_o`=1 and `out_ready_i`=0, the presented rectangle and `out_valid_o` stay unchanged. An entry leaves the queue only on a cycle with valid and ready both high.
- R4: Horizontal clipping uses the live `scr_w_i`. If x+w > `scr_w_i`, then x becomes min(x, `scr_w_i`) and w becomes `scr_w_i` minus that new x. Otherwise x and w pass through unchanged.
- R5: Vertical clipping applies the same rule to y and h against the live `scr_h_i`.
- R6: A rectangle whose clipped width or clipped height is 0 is dropped, and draining continues with the next entry.
- R7: A flush while an invalidate is pending discards every stored entry and presents nothing. `empty_o` becomes 1 and the pending flag clears, so the next flush drains normally.
- R8: An invalidate strobe on its own changes neither the stored entries nor the outputs until a flush arrives.
- R9: Capacity is DEPTH entries. A push into a full queue sets the sticky `overflow_o` and replaces the oldest entry, so the queue keeps the newest DEPTH rectangles.
- R10: Pushes without a flush never raise `out_valid_o`.
- R11: A drain stops once the queue is empty. Rectangles pushed after that wait for the next flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Store the rectangle on the push fields |
| push_x_i | input | 16 | Left coordinate of the pushed rectangle |
| push_y_i | input | 16 | Top coordinate of the pushed rectangle |
| push_w_i | input | 16 | Width of the pushed rectangle |
| push_h_i | input | 16 | Height of the pushed rectangle |
| flush_i | input | 1 | Start a drain, or a discard if an invalidate is pending |
| inval_i | input | 1 | Arm a full-screen invalidate |
| scr_w_i | input | 16 | Current screen width |
| scr_h_i | input | 16 | Current screen height |
| out_valid_o | output | 1 | Clipped rectangle available |
| out_ready_i | input | 1 | Consumer accepts the rectangle |
| out_x_o | output | 16 | Clipped left coordinate |
| out_y_o | output | 16 | Clipped top coordinate |
| out_w_o | output | 16 | Clipped width |
| out_h_o | output | 16 | Clipped height |
| empty_o | output | 1 | No entries stored |
| overflow_o | output | 1 | Sticky: a push landed on a full queue |

## Verification
The bench covers rectangles that end exactly on the screen edge, rectangles that cross the edge, and rectangles that start beyond it. A design that compared with the wrong relation or forgot to pull x back would emit spans past the edge, or would underflow to a huge width. Zero-width rectangles and rectangles that clip to zero are mixed into the stream, so a design that emitted them, or stalled on them, would show up in the received sequence. An invalidate is armed before a flush, and a later flush follows it. Keeping the pending flag would wrongly discard that second batch, and ignoring the flag would emit stale work. A DEPTH+1 push run checks that the single oldest entry is lost and that overflow is sticky, and alternating backpressure catches any entry dropped or altered while stalled.

// File: rtl/drq_pkg.sv
package drq_pkg;
  localparam int unsigned DRQ_CW = 16;

  typedef struct packed {
    logic [DRQ_CW-1:0] x;
    logic [DRQ_CW-1:0] y;
    logic [DRQ_CW-1:0] w;
    logic [DRQ_CW-1:0] h;
  } drq_rect_t;
endpackage

// File: rtl/drq_store.sv
module drq_store
  import drq_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  drq_rect_t     wr_data_i,
  input  logic [AW-1:0] rd_idx_i,
  output drq_rect_t     rd_data_o
);
  drq_rect_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/drq_ptrs.sv
module drq_ptrs #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          discard_i,
  output logic [AW-1:0] wr_idx_o,
  output logic [AW-1:0] rd_idx_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o
);
  // extra msb is a lap bit: same index, different lap => full
  logic [AW:0] wr_q, rd_q;
  logic        ovf_q;
  logic        clobber;

  assign empty_o  = (wr_q == rd_q);
  assign full_o   = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign wr_idx_o = wr_q[AW-1:0];
  assign rd_idx_o = rd_q[AW-1:0];
  assign ovf_o    = ovf_q;
  assign clobber  = push_i && full_o && !pop_i && !discard_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (discard_i)                rd_q <= wr_q;
      else if (pop_i || clobber)    rd_q <= rd_q + 1'b1;
      if (clobber) ovf_q <= 1'b1;
    end
  end

  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);

  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q - rd_q) <= (AW+1)'(DEPTH));

  a_r2_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

  a_r7_discard_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_i && !push_i |=> empty_o);
endmodule

// File: rtl/drq_clip_axis.sv
module drq_clip_axis #(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0] pos_i,
  input  logic [CW-1:0] len_i,
  input  logic [CW-1:0] lim_i,
  output logic [CW-1:0] pos_o,
  output logic [CW-1:0] len_o
);
  logic [CW:0] end_w;
  assign end_w = {1'b0, pos_i} + {1'b0, len_i};

  always_comb begin
    pos_o = pos_i;
    len_o = len_i;
    if (end_w > {1'b0, lim_i}) begin
      pos_o = (pos_i > lim_i) ? lim_i : pos_i;
      len_o = lim_i - pos_o;
    end
  end
endmodule

// File: rtl/dirty_rect_queue.sv
module dirty_rect_queue
  import drq_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = DRQ_CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [CW-1:0] push_x_i,
  input  logic [CW-1:0] push_y_i,
  input  logic [CW-1:0] push_w_i,
  input  logic [CW-1:0] push_h_i,
  input  logic          flush_i,
  input  logic          inval_i,
  input  logic [CW-1:0] scr_w_i,
  input  logic [CW-1:0] scr_h_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [CW-1:0] out_x_o,
  output logic [CW-1:0] out_y_o,
  output logic [CW-1:0] out_w_o,
  output logic [CW-1:0] out_h_o,
  output logic          empty_o,
  output logic          overflow_o
);
  logic          drain_q, pend_q;
  logic          pop, discard, full, empty, rec_ok;
  logic [AW-1:0] wr_idx, rd_idx;
  drq_rect_t     wr_rec, rd_rec;

  logic [CW-1:0] ax_pos [2];
  logic [CW-1:0] ax_len [2];
  logic [CW-1:0] ax_lim [2];
  logic [CW-1:0] cl_pos [2];
  logic [CW-1:0] cl_len [2];

  assign wr_rec = '{x: push_x_i, y: push_y_i, w: push_w_i, h: push_h_i};

  drq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (push_i),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_rec),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_rec)
  );

  drq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push_i),
    .pop_i     (pop),
    .discard_i (discard),
    .wr_idx_o  (wr_idx),
    .rd_idx_o  (rd_idx),
    .empty_o   (empty),
    .full_o    (full),
    .ovf_o     (overflow_o)
  );

  assign ax_pos[0] = rd_rec.x;
  assign ax_len[0] = rd_rec.w;
  assign ax_lim[0] = scr_w_i;
  assign ax_pos[1] = rd_rec.y;
  assign ax_len[1] = rd_rec.h;
  assign ax_lim[1] = scr_h_i;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    drq_clip_axis #(.CW(CW)) u_clip (
      .pos_i (ax_pos[g]),
      .len_i (ax_len[g]),
      .lim_i (ax_lim[g]),
      .pos_o (cl_pos[g]),
      .len_o (cl_len[g])
    );
  end

  assign rec_ok      = (cl_len[0] != '0) && (cl_len[1] != '0);
  assign out_valid_o = drain_q && !empty && rec_ok;
  // zero-size entries are skipped without a handshake
  assign pop         = drain_q && !empty && (!rec_ok || out_ready_i);
  assign discard     = flush_i && pend_q;
  assign out_x_o     = cl_pos[0];
  assign out_w_o     = cl_len[0];
  assign out_y_o     = cl_pos[1];
  assign out_h_o     = cl_len[1];
  assign empty_o     = empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (flush_i) drain_q <= !pend_q;
      else         drain_q <= drain_q && !empty;
      pend_q <= (pend_q && !flush_i) || inval_i;
    end
  end

  a_r3_hold_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !flush_i && !(push_i && full)
    |=> rd_idx == $past(rd_idx));

  a_r4_x_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ({1'b0, out_x_o} + {1'b0, out_w_o}) <= {1'b0, scr_w_i});

  a_r5_y_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ({1'b0, out_y_o} + {1'b0, out_h_o}) <= {1'b0, scr_h_i});

  a_r6_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_w_o != '0) && (out_h_o != '0));

  a_r7_discard_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && pend_q && !push_i |=> !out_valid_o && empty_o);
endmodule

// File: tb/dirty_rect_queue_test.sv
module dirty_rect_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 512;
  localparam int NV = 9;
  // x, y, w, h, exp x, exp y, exp w, exp h (screen 100 x 80)
  localparam int VEC [NV][8] = '{
    '{ 10, 10, 20, 20,  10, 10, 20, 20},
    '{ 90,  5, 20,  5,  90,  5, 10,  5},
    '{  5, 70,  4, 30,   5, 70,  4, 10},
    '{120, 10,  5,  5, 100, 10,  0,  5},
    '{  0,  0,100, 80,   0,  0,100, 80},
    '{ 99, 79,  1,  1,  99, 79,  1,  1},
    '{ 50, 50,  0,  5,  50, 50,  0,  5},
    '{ 30, 90, 10, 10,  30, 80, 10,  0},
    '{200,200,300,300, 100, 80,  0,  0}
  };

  logic clk = 0, rst_ni = 0;
  logic push_i = 0, flush_i = 0, inval_i = 0, out_ready_i = 0;
  logic [15:0] push_x_i = 0, push_y_i = 0, push_w_i = 0, push_h_i = 0;
  logic [15:0] scr_w_i = 100, scr_h_i = 80;
  logic out_valid_o, empty_o, overflow_o;
  logic [15:0] out_x_o, out_y_o, out_w_o, out_h_o;

  int total = 0, bad = 0, hold_err = 0, got_n = 0;
  bit done = 0;
  int got_x [DEPTH+8];
  int got_y [DEPTH+8];
  int got_w [DEPTH+8];
  int got_h [DEPTH+8];

  dirty_rect_queue #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i),
    .push_x_i(push_x_i), .push_y_i(push_y_i), .push_w_i(push_w_i), .push_h_i(push_h_i),
    .flush_i(flush_i), .inval_i(inval_i), .scr_w_i(scr_w_i), .scr_h_i(scr_h_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_x_o(out_x_o), .out_y_o(out_y_o), .out_w_o(out_w_o), .out_h_o(out_h_o),
    .empty_o(empty_o), .overflow_o(overflow_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int x, input int y, input int w, input int h);
    @(negedge clk);
    push_i = 1; push_x_i = 16'(x); push_y_i = 16'(y); push_w_i = 16'(w); push_h_i = 16'(h);
    @(posedge clk); #1 push_i = 0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush_i = 1;
    @(posedge clk); #1 flush_i = 0;
  endtask

  task automatic pulse_inval();
    @(negedge clk); inval_i = 1;
    @(posedge clk); #1 inval_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bp=1 alternates ready; checks the presented entry holds while stalled (R3)
  task automatic collect(input int ncyc, input bit bp);
    bit stalled = 0;
    int px = 0, py = 0, pw = 0, ph = 0;
    got_n = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      out_ready_i = bp ? c[0] : 1'b1;
      if (stalled && (!out_valid_o || out_x_o != 16'(px) || out_y_o != 16'(py) ||
                      out_w_o != 16'(pw) || out_h_o != 16'(ph)))
        hold_err++;
      stalled = out_valid_o && !out_ready_i;
      px = out_x_o; py = out_y_o; pw = out_w_o; ph = out_h_o;
      if (out_valid_o && out_ready_i && got_n < DEPTH+8) begin
        got_x[got_n] = out_x_o; got_y[got_n] = out_y_o;
        got_w[got_n] = out_w_o; got_h[got_n] = out_h_o;
        got_n++;
      end
    end
    @(negedge clk); out_ready_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int j, err;
    idle(3);
    rst_ni = 1;
    @(negedge clk);
    chk(empty_o == 1, "R1 empty", empty_o, 1);
    chk(out_valid_o == 0, "R1 valid", out_valid_o, 0);
    chk(overflow_o == 0, "R1 overflow", overflow_o, 0);

    // table walk: R2 R4 R5 R6
    for (int i = 0; i < NV; i++) push(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
    idle(3);
    chk(out_valid_o == 0, "R10 no flush no output", out_valid_o, 0);
    chk(empty_o == 0, "R10 entries stored", empty_o, 0);
    pulse_flush();
    collect(40, 1'b1);
    j = 0; err = 0;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][6] != 0 && VEC[i][7] != 0) begin
        if (j >= got_n || got_x[j] != VEC[i][4] || got_y[j] != VEC[i][5] ||
            got_w[j] != VEC[i][6] || got_h[j] != VEC[i][7]) err++;
        j++;
      end
    end
    chk(got_n == j, "R6 kept count", got_n, j);
    chk(err == 0, "R2 R4 R5 order and clipping", err, 0);
    chk(empty_o == 1, "R2 empty after drain", empty_o, 1);
    chk(hold_err == 0, "R3 hold under backpressure", hold_err, 0);

    // R11: push after drain end waits for next flush
    push(1, 1, 1, 1);
    idle(4);
    chk(out_valid_o == 0, "R11 no output after drain end", out_valid_o, 0);
    pulse_flush();
    collect(6, 1'b0);
    chk(got_n == 1 && got_x[0] == 1, "R11 later flush drains", got_n, 1);

    // R8 then R7
    push(3, 3, 3, 3); push(4, 4, 4, 4); push(5, 5, 5, 5);
    pulse_inval();
    idle(3);
    chk(empty_o == 0, "R8 inval alone keeps entries", empty_o, 0);
    chk(out_valid_o == 0, "R8 inval alone no output", out_valid_o, 0);
    pulse_flush();
    collect(8, 1'b0);
    chk(got_n == 0, "R7 discard emits nothing", got_n, 0);
    chk(empty_o == 1, "R7 discard empties", empty_o, 1);
    push(2, 2, 2, 2);
    pulse_flush();
    collect(6, 1'b0);
    chk(got_n == 1 && got_x[0] == 2, "R7 pending cleared", got_n, 1);

    // R4 live width at drain time
    push(40, 0, 30, 10);
    @(negedge clk); scr_w_i = 50;
    pulse_flush();
    collect(6, 1'b0);
    chk(got_n == 1 && got_x[0] == 40 && got_w[0] == 10, "R4 live width clip", got_w[0], 10);
    // R5 start beyond bottom edge pulled back, zero height dropped; other kept
    scr_w_i = 100;
    push(0, 85, 5, 5); push(0, 60, 5, 40);
    pulse_flush();
    collect(8, 1'b0);
    chk(got_n == 1 && got_y[0] == 60 && got_h[0] == 20, "R5 y clip", got_h[0], 20);

    // R9 overflow
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    scr_w_i = 1000;
    for (int i = 0; i < DEPTH; i++) push(i, 0, 1, 1);
    @(negedge clk);
    chk(overflow_o == 0, "R9 full no overflow", overflow_o, 0);
    push(DEPTH, 0, 1, 1);
    @(negedge clk);
    chk(overflow_o == 1, "R9 overflow set", overflow_o, 1);
    pulse_flush();
    collect(DEPTH + 20, 1'b0);
    err = 0;
    for (int k = 0; k < got_n; k++) if (got_x[k] != k + 1) err++;
    chk(got_n == DEPTH, "R9 newest kept count", got_n, DEPTH);
    chk(err == 0, "R9 oldest overwritten", err, 0);
    chk(overflow_o == 1, "R9 overflow sticky", overflow_o, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule